// File: doc/BRIEF.md
# Programmable audio master clock generator

This block runs on a high-rate audio source clock and derives three timing signals from it: an audio master clock for an external converter, a one-cycle frame pulse at the sample rate, and a bit-tick enable that paces a stereo serializer. Two 6-bit ratio fields set the timing. The master clock is the source divided by (DIV+1). The frame rate is the source divided by 32·(FS+1). Together these give a master clock of 32·(FS+1)/(DIV+1) times the sample rate.

Software first writes the ratios and a master-clock-pin enable into a 32-bit mode word, then issues a start command. To shut down it issues a stop command and clears the fields afterwards. The ratios are held in a staging copy and reach the dividers only while the generator is stopped. A write made while the generator runs therefore waits for the next start. A status output shows whether the generator is running.

Top module: `audio_mclk_gen`

## Requirements
- R1: The mode word is decoded as follows: the master-clock divide field DIV is bits 21:16, the frame ratio field FS is bits 29:24, and the pin enable is bit 30. All other bits have no effect on any output.
- R2: A start command makes `running` high from the next cycle. A stop command makes it low from the next cycle. When both are given in the same cycle, stop wins.
- R3: While `running` is low, `mclk_o`, `frame_pulse` and `bclk_en` are all low. This holds after reset and after every stop.
- R4: Counting cycles from the first running cycle (cycle 0), `mclk_o` repeats every DIV+1 cycles. In each period it is high for the first ceil((DIV+1)/2) cycles and then low. With DIV=0, `mclk_o` follows the source clock.
- R5: With the pin enable at 0, `mclk_o` stays low while the frame pulse and bit ticks keep running.
- R6: `frame_pulse` is high for one cycle at every cycle index 32·(FS+1)·m − 1 (m = 1, 2, …). The first pulse therefore comes one whole frame after start.
- R7: Each frame holds exactly 64 `bclk_en` ticks when FS ≥ 1, and 32 ticks (one per cycle) when FS = 0. The frame's last tick falls in the same cycle as `frame_pulse`.
- R8: A mode write made while running leaves all outputs unchanged until a stop and a new start. A mode write given in the same cycle as start takes effect for that start.
- R9: With DIV=7, FS=63, each frame holds 256 master clock periods. With DIV=7, FS=15, each frame holds 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | High-rate audio source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Mode word write strobe |
| mode_wdata | input | 32 | Mode word (DIV, FS, pin enable) |
| cmd_start | input | 1 | Clock-enable command pulse |
| cmd_stop | input | 1 | Clock-disable command pulse |
| running | output | 1 | Generator running status |
| mclk_o | output | 1 | Generated master clock for the pin |
| frame_pulse | output | 1 | One-cycle pulse per audio frame |
| bclk_en | output | 1 | Bit-tick enable for the serializer |

## Verification
The bench targets the following cases:
- Odd divide values and the DIV=0 pass-through. A wrong high-phase length or a dropped pass-through would distort the master clock waveform cycle by cycle.
- An even FS+1 and an odd FS+1 with a non-integer half ratio. A bit-tick divider that rounded would give 62 or 66 ticks per frame, or put its last tick off the frame pulse.
- A ratio rewrite mid-run, and a write in the same cycle as start. A design without the staging copy would change pitch mid-stream, and one that sampled the staging copy a cycle late would start with stale ratios.
- Start and stop together, and mode words carrying stray bits. These expose a wrong command priority or a decode at the wrong bit positions.

// File: rtl/audio_mclk_gen.sv
module audio_mclk_gen #(
  parameter int MODE_W    = 32,
  parameter int DIV_W     = 6,
  parameter int FS_W      = 6,
  parameter int DIV_LSB   = 16,
  parameter int FS_LSB    = 24,
  parameter int MCK_BIT   = 30,
  parameter int SLOT_BITS = 32
) (
  input  logic              clk_src,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  output logic              running,
  output logic              mclk_o,
  output logic              frame_pulse,
  output logic              bclk_en
);
  localparam int SLOT_LOG = $clog2(SLOT_BITS);
  localparam int FR_W     = FS_W + SLOT_LOG;
  localparam int ACC_W    = ((FS_W > SLOT_LOG) ? FS_W : SLOT_LOG) + 2;

  logic [DIV_W-1:0] sh_div, act_div, nx_div, mc_cnt;
  logic [FS_W-1:0]  sh_fs, act_fs, nx_fs;
  logic             sh_mck, act_mck, nx_mck, run_q;
  logic [FR_W-1:0]  fr_cnt, fr_end;
  logic [ACC_W-1:0] acc, acc_sum, n_fs;
  logic [DIV_W:0]   mc_hi;
  logic             fr_last, bit_hit, mclk_lvl;

  assign nx_div = mode_we ? mode_wdata[DIV_LSB +: DIV_W] : sh_div;
  assign nx_fs  = mode_we ? mode_wdata[FS_LSB +: FS_W]   : sh_fs;
  assign nx_mck = mode_we ? mode_wdata[MCK_BIT]          : sh_mck;

  assign fr_end  = {act_fs, {SLOT_LOG{1'b1}}};
  assign fr_last = (fr_cnt == fr_end);
  assign n_fs    = ACC_W'(act_fs) + ACC_W'(1);
  assign acc_sum = acc + ACC_W'(2);
  assign bit_hit = (acc_sum >= n_fs);
  assign mc_hi   = ({1'b0, act_div} + (DIV_W+1)'(2)) >> 1;
  assign mclk_lvl = ({1'b0, mc_cnt} < mc_hi);

  always_ff @(posedge clk_src) begin
    if (!rst_n) begin
      sh_div <= '0; sh_fs <= '0; sh_mck <= 1'b0;
      act_div <= '0; act_fs <= '0; act_mck <= 1'b0;
      run_q <= 1'b0;
    end else begin
      sh_div <= nx_div; sh_fs <= nx_fs; sh_mck <= nx_mck;
      if (!run_q) begin
        act_div <= nx_div; act_fs <= nx_fs; act_mck <= nx_mck;
      end
      if (cmd_stop)       run_q <= 1'b0;
      else if (cmd_start) run_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_src) begin
    if (!rst_n || !run_q) begin
      mc_cnt <= '0;
      fr_cnt <= '0;
      acc    <= '0;
    end else begin
      mc_cnt <= (mc_cnt == act_div) ? '0 : mc_cnt + DIV_W'(1);
      fr_cnt <= fr_last ? '0 : fr_cnt + FR_W'(1);
      if (fr_last)      acc <= '0;
      else if (bit_hit) acc <= acc_sum - n_fs;
      else              acc <= acc_sum;
    end
  end

  assign running     = run_q;
  assign frame_pulse = run_q & fr_last;
  assign bclk_en     = run_q & bit_hit;
  assign mclk_o      = run_q & act_mck & ((act_div == '0) ? clk_src : mclk_lvl);

  p_stop_wins_r2: assert property (@(posedge clk_src) disable iff (!rst_n)
    cmd_stop |=> !running);
  p_start_sets_r2: assert property (@(posedge clk_src) disable iff (!rst_n)
    (cmd_start && !cmd_stop) |=> running);
  p_idle_reset_r3: assert property (@(posedge clk_src) disable iff (!rst_n)
    (!run_q && $past(!run_q)) |-> (fr_cnt == '0 && acc == '0 && mc_cnt == '0));
  p_frame_gap_r6: assert property (@(posedge clk_src) disable iff (!rst_n)
    frame_pulse |=> !frame_pulse);
  p_last_tick_r7: assert property (@(posedge clk_src) disable iff (!rst_n)
    frame_pulse |-> bclk_en);
  p_cfg_hold_r8: assert property (@(posedge clk_src) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> ($stable(act_div) && $stable(act_fs) && $stable(act_mck)));
endmodule

// File: tb/audio_mclk_gen_bench.sv
module audio_mclk_gen_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, mode_we, cmd_start, cmd_stop;
  logic [31:0] mode_wdata;
  logic running, mclk_o, frame_pulse, bclk_en;

  audio_mclk_gen u_audio_mclk_gen (
    .clk_src(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .running(running),
    .mclk_o(mclk_o), .frame_pulse(frame_pulse), .bclk_en(bclk_en));

  int errors = 0, checks = 0;
  int m_div = 0, m_fs = 0, exp_rises = 0;
  bit m_mck = 0, rise_chk = 0, prev_mclk = 0;
  int k = 0, bc_cnt = 0, rise_cnt = 0, mck_bad = 0, idle_bad = 0;
  int exp_q[$];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word(int div, int fs, bit mck, logic [31:0] junk);
    return (junk & 32'h80C0FFFF) | (32'(div) << 16) | (32'(fs) << 24) | (32'(mck) << 30);
  endfunction

  // monitor: samples 2 ns after each rising edge
  initial forever begin
    @(posedge clk); #2;
    if (!rst_n || !running) begin
      if (rst_n && (mclk_o || frame_pulse || bclk_en)) idle_bad++;
      k = 0; bc_cnt = 0; rise_cnt = 0; prev_mclk = 0;
    end else begin
      automatic int n = m_div + 1;
      automatic bit exp_m = m_mck && (n == 1 || (k % n) < (n + 1) / 2);
      if (mclk_o !== exp_m) mck_bad++;
      if (mclk_o && !prev_mclk) rise_cnt++;
      prev_mclk = mclk_o;
      if (bclk_en) bc_cnt++;
      if (frame_pulse) begin
        if (exp_q.size() == 0) chk("R6", "unexpected frame pulse at cycle", k, -1);
        else chk("R6", "frame pulse cycle", k, exp_q.pop_front());
        chk("R7", "bit ticks in frame", bc_cnt, (m_fs == 0) ? 32 : 64);
        if (rise_chk) chk("R9", "master clock periods in frame", rise_cnt, exp_rises);
        bc_cnt = 0; rise_cnt = 0;
      end
      k++;
    end
  end

  task automatic wr_mode(int div, int fs, bit mck, logic [31:0] junk);
    @(negedge clk); mode_wdata = word(div, fs, mck, junk); mode_we = 1'b1;
    @(negedge clk); mode_we = 1'b0;
  endtask

  // driver: pushes expected frame stamps, starts, runs, stops
  task automatic run(string req, int frames, int div, int fs, bit mck,
                     bit wr_start, bit mid_en, logic [31:0] mid_word, int rises);
    int n = 32 * (fs + 1);
    m_div = div; m_fs = fs; m_mck = mck;
    rise_chk = (rises > 0); exp_rises = rises;
    for (int f = 1; f <= frames; f++) exp_q.push_back(f * n - 1);
    mck_bad = 0; idle_bad = 0;
    @(negedge clk); cmd_start = 1'b1;
    if (wr_start) begin mode_wdata = word(div, fs, mck, 32'h0); mode_we = 1'b1; end
    @(negedge clk); cmd_start = 1'b0; mode_we = 1'b0;
    chk("R2", "running after start", int'(running), 1);
    for (int i = 0; i < frames * n + 1; i++) begin
      if (mid_en && i == 10) begin mode_wdata = mid_word; mode_we = 1'b1; end
      else mode_we = 1'b0;
      @(negedge clk);
    end
    mode_we = 1'b0;
    cmd_stop = 1'b1;
    @(negedge clk); cmd_stop = 1'b0;
    chk("R2", "running after stop", int'(running), 0);
    @(negedge clk); @(negedge clk);
    chk(req, "master clock waveform mismatches", mck_bad, 0);
    chk("R6", "frame pulses still owed", exp_q.size(), 0);
    chk("R3", "outputs active while stopped", idle_bad, 0);
    exp_q.delete();
  endtask

  initial begin
    #2_000_000;
    chk("WD", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_we = 1'b0; cmd_start = 1'b0; cmd_stop = 1'b0; mode_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3", "running after reset", int'(running), 0);
    chk("R3", "mclk_o after reset", int'(mclk_o), 0);
    chk("R3", "frame_pulse after reset", int'(frame_pulse), 0);
    chk("R3", "bclk_en after reset", int'(bclk_en), 0);

    // R1 / R9: 48 kHz ratios with stray bits in the mode word
    wr_mode(7, 63, 1, 32'h80C0A5A5);
    run("R1", 2, 7, 63, 1, 0, 0, 32'h0, 256);
    // R9: 192 kHz ratios
    wr_mode(7, 15, 1, 32'h0);
    run("R9", 2, 7, 15, 1, 0, 0, 32'h0, 64);
    // R4 / R7: odd divide, odd FS+1
    wr_mode(4, 2, 1, 32'h0);
    run("R4", 3, 4, 2, 1, 0, 0, 32'h0, 0);
    // R4: DIV=0 pass-through, FS=0
    wr_mode(0, 0, 1, 32'h0);
    run("R4", 3, 0, 0, 1, 0, 0, 32'h0, 0);
    // R5: pin disabled, stray bits set
    wr_mode(2, 5, 0, 32'hFFFFFFFF);
    run("R5", 2, 2, 5, 0, 0, 0, 32'h0, 0);
    // R8: rewrite mid-run is held, then applies on next start
    wr_mode(3, 1, 1, 32'h0);
    run("R8", 2, 3, 1, 1, 0, 1, word(5, 7, 0, 32'h0), 0);
    run("R8", 2, 5, 7, 0, 0, 0, 32'h0, 0);
    // R2: start and stop together while stopped
    @(negedge clk); cmd_start = 1'b1; cmd_stop = 1'b1;
    @(negedge clk); cmd_start = 1'b0; cmd_stop = 1'b0;
    chk("R2", "running after start with stop", int'(running), 0);
    // R8: write in the start cycle takes effect
    run("R8", 2, 1, 3, 1, 1, 0, 32'h0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule